// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block holds the atomic reservation of one processor core. A load-linked request arms a single reservation flag and records which 32-byte cache line was read. Three kinds of event disarm the flag: the core entering an exception or interrupt handler, another agent writing anywhere in the recorded line (seen as a snooped bus write), and the completion of any store-conditional.

A store-conditional is judged against that flag and the recorded line. If the reservation does not hold, the block answers "fail" on the next cycle and nothing is written. If it holds, the block asks the cache for exclusive ownership of the line and waits for the grant. It then reports "pass" and raises a store-commit strobe, unless a disarming event arrived while it was waiting. No locked or atomic bus cycle is ever produced. Success depends only on the flag and the line comparison.

Top module: `llsc_resv_monitor`

## Requirements
- R1: A load-linked request arms the reservation. A store-conditional to the same line that follows it raises `upg_req` in the next cycle and, after the grant, reports a pass.
- R2: An `exc_pulse` disarms the reservation, so a later store-conditional fails.
- R3: A store-conditional made while the reservation is disarmed gives `sc_done`=1, `sc_pass`=0 and `commit_stb`=0 in the next cycle, and `upg_req` is never raised for it.
- R4: A snooped write disarms the reservation when its address bits [31:5] equal those of the recorded line, whatever the byte offset. A snooped write to a different line has no effect.
- R5: A store-conditional whose address bits [31:5] differ from the recorded line fails without an upgrade request.
- R6: `upg_req` stays high from the cycle after an accepted store-conditional up to and including the cycle in which `upg_gnt` is seen, and it is low in the next cycle. `upg_gnt` has no effect while `upg_req` is low.
- R7: `sc_done` is a one-cycle pulse. `commit_stb` pulses together with it only when `sc_pass`=1, and on a pass this happens in the cycle after the grant.
- R8: Every completed store-conditional, whether it passes or fails, disarms the reservation. A second store-conditional without a new load-linked fails.
- R9: An exception pulse or a matching snoop that arrives while `upg_req` is high makes the pending store-conditional fail when the grant comes, with no commit strobe.
- R10: When a load-linked coincides with an exception pulse, or with a snooped write to the line being linked, the reservation stays disarmed.
- R11: A new load-linked replaces the recorded line.
- R12: Reset leaves all outputs low and the reservation disarmed.
- R13: A store-conditional that coincides with an exception pulse or with a matching snoop fails immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_valid | input | 1 | Load-linked request |
| ll_addr | input | 32 | Load-linked address |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | 32 | Store-conditional address |
| exc_pulse | input | 1 | Exception or interrupt handler entry |
| snoop_valid | input | 1 | Snooped write by another agent |
| snoop_addr | input | 32 | Snooped write address |
| upg_gnt | input | 1 | Exclusive-ownership grant from the cache |
| upg_req | output | 1 | Exclusive-ownership upgrade request |
| sc_done | output | 1 | Store-conditional result valid (one cycle) |
| sc_pass | output | 1 | Store-conditional succeeded (valid with sc_done) |
| commit_stb | output | 1 | Perform the store (one cycle) |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is arming by a load-linked together with disarming by an exception or a same-line snoop. The second pair is the ownership grant together with a disarming event. The bench provokes the first pair by driving the load-linked and the clearing input on one clock edge, and then judges the outcome by whether a later store-conditional fails without an upgrade request. It provokes the second pair by injecting the clearing input while the upgrade is pending and checks that the result arrives after the grant as a fail with no commit strobe.

// File: rtl/llsc_resv_pkg.sv
package llsc_resv_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/llsc_rst_sync.sv
module llsc_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/llsc_line_cmp.sv
module llsc_line_cmp #(
  parameter int TAG_W = 27
) (
  input  logic [TAG_W-1:0] tag_a,
  input  logic [TAG_W-1:0] tag_b,
  output logic             same
);
  assign same = (tag_a == tag_b);
endmodule

// File: rtl/llsc_link_reg.sv
module llsc_link_reg #(
  parameter int TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ll_valid,
  input  logic [TAG_W-1:0] ll_tag,
  input  logic             exc_pulse,
  input  logic             snoop_valid,
  input  logic [TAG_W-1:0] snoop_tag,
  input  logic             sc_fin,
  output logic             link_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             clr_now_o
);
  logic             link_q, link_d;
  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] watch_tag;
  logic             snoop_same;
  logic             snoop_hit;
  logic             clr_all;

  // A load-linked in this cycle redirects the watch to the new line.
  assign watch_tag = ll_valid ? ll_tag : tag_q;

  llsc_line_cmp #(.TAG_W(TAG_W)) u_snoop_cmp (
    .tag_a (snoop_tag),
    .tag_b (watch_tag),
    .same  (snoop_same)
  );

  assign snoop_hit = snoop_valid & snoop_same;
  assign clr_now_o = exc_pulse | snoop_hit;
  assign clr_all   = clr_now_o | sc_fin;

  always_comb begin
    link_d = link_q;
    if (clr_all)       link_d = 1'b0;
    else if (ll_valid) link_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tag_q <= '0;
    else if (ll_valid) tag_q <= ll_tag;
  end

  assign link_o = link_q;
  assign tag_o  = tag_q;

  assert_exc_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |=> !link_q);

  assert_fin_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fin |=> !link_q);

  assert_ll_arms_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_valid && !exc_pulse && !snoop_valid && !sc_fin) |=> link_q);

  assert_snoop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && !ll_valid && snoop_tag == tag_q) |=> !link_q);

  assert_ll_records_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ll_valid |=> tag_q == $past(ll_tag));
endmodule

// File: rtl/llsc_sc_seq.sv
module llsc_sc_seq
  import llsc_resv_pkg::*;
#(
  parameter int TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sc_valid,
  input  logic [TAG_W-1:0] sc_tag,
  input  logic             link_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             clr_now_i,
  input  logic             upg_gnt,
  output logic             upg_req,
  output logic             sc_fin,
  output logic             sc_done,
  output logic             sc_pass,
  output logic             commit_stb
);
  seq_state_e state_q, state_d;
  logic       done_q, done_d;
  logic       pass_q, pass_d;
  logic       commit_q, commit_d;
  logic       line_same;
  logic       resv_ok;
  logic       res_ok;

  llsc_line_cmp #(.TAG_W(TAG_W)) u_sc_cmp (
    .tag_a (sc_tag),
    .tag_b (tag_i),
    .same  (line_same)
  );

  assign resv_ok = link_i & line_same & ~clr_now_i;

  always_comb begin
    state_d = state_q;
    sc_fin  = 1'b0;
    res_ok  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (sc_valid) begin
          if (resv_ok) begin
            state_d = SEQ_WAIT;
          end else begin
            sc_fin = 1'b1;
          end
        end
      end
      SEQ_WAIT: begin
        if (upg_gnt) begin
          sc_fin  = 1'b1;
          res_ok  = link_i & ~clr_now_i;
          state_d = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
    done_d   = sc_fin;
    pass_d   = sc_fin & res_ok;
    commit_d = sc_fin & res_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      pass_q   <= pass_d;
      commit_q <= commit_d;
    end
  end

  assign upg_req    = (state_q == SEQ_WAIT);
  assign sc_done    = done_q;
  assign sc_pass    = pass_q;
  assign commit_stb = commit_q;

  assert_req_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upg_req && !upg_gnt) |=> upg_req);

  assert_gnt_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upg_req && upg_gnt) |=> (sc_done && !upg_req));

  assert_commit_after_gnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> $past(upg_req && upg_gnt && link_i));

  assert_unlinked_fails_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !upg_req && !link_i) |=> (sc_done && !sc_pass && !upg_req));

  assert_pending_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upg_req && upg_gnt && clr_now_i) |=> !commit_stb);
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              exc_pulse,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              upg_gnt,
  output logic              upg_req,
  output logic              sc_done,
  output logic              sc_pass,
  output logic              commit_stb
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic             rst_s_n;
  logic             link;
  logic [TAG_W-1:0] rec_tag;
  logic             clr_now;
  logic             sc_fin;
  logic             unused_offsets;

  assign unused_offsets = ^{ll_addr[OFF_W-1:0], sc_addr[OFF_W-1:0], snoop_addr[OFF_W-1:0]};

  llsc_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s_n)
  );

  llsc_link_reg #(.TAG_W(TAG_W)) u_link (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .ll_valid    (ll_valid),
    .ll_tag      (ll_addr[ADDR_W-1:OFF_W]),
    .exc_pulse   (exc_pulse),
    .snoop_valid (snoop_valid),
    .snoop_tag   (snoop_addr[ADDR_W-1:OFF_W]),
    .sc_fin      (sc_fin),
    .link_o      (link),
    .tag_o       (rec_tag),
    .clr_now_o   (clr_now)
  );

  llsc_sc_seq #(.TAG_W(TAG_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .sc_valid   (sc_valid),
    .sc_tag     (sc_addr[ADDR_W-1:OFF_W]),
    .link_i     (link),
    .tag_i      (rec_tag),
    .clr_now_i  (clr_now),
    .upg_gnt    (upg_gnt),
    .upg_req    (upg_req),
    .sc_fin     (sc_fin),
    .sc_done    (sc_done),
    .sc_pass    (sc_pass),
    .commit_stb (commit_stb)
  );

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sc_done && !sc_valid && !upg_req) |=> !sc_done);
endmodule

// File: tb/llsc_resv_monitor_test.sv
module llsc_resv_monitor_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ll_valid, sc_valid, exc_pulse, snoop_valid, upg_gnt;
  logic [31:0] ll_addr, sc_addr, snoop_addr;
  logic        upg_req, sc_done, sc_pass, commit_stb;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  localparam logic [31:0] LINE_A  = 32'h0000_1040;
  localparam logic [31:0] BYTE_A  = 32'h0000_1045;
  localparam logic [31:0] LINE_B  = 32'h0000_1060;
  localparam logic [31:0] LINE_C  = 32'h0000_2000;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_resv_monitor uut (
    .clk(clk), .rst_n(rst_n),
    .ll_valid(ll_valid), .ll_addr(ll_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr),
    .exc_pulse(exc_pulse),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .upg_gnt(upg_gnt), .upg_req(upg_req),
    .sc_done(sc_done), .sc_pass(sc_pass), .commit_stb(commit_stb)
  );

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_ll(input logic [31:0] a, input bit ex, input bit sn,
                       input logic [31:0] sa);
    @(negedge clk);
    ll_valid = 1'b1; ll_addr = a;
    exc_pulse = ex; snoop_valid = sn; snoop_addr = sa;
    @(negedge clk);
    ll_valid = 1'b0; exc_pulse = 1'b0; snoop_valid = 1'b0;
  endtask

  task automatic do_exc();
    @(negedge clk); exc_pulse = 1'b1;
    @(negedge clk); exc_pulse = 1'b0;
  endtask

  task automatic do_snoop(input logic [31:0] sa);
    @(negedge clk); snoop_valid = 1'b1; snoop_addr = sa;
    @(negedge clk); snoop_valid = 1'b0;
  endtask

  // One store-conditional: ex0/sn0 coincide with the request, exm/snm land in the
  // first cycle of a pending upgrade, the grant comes after gap waiting cycles.
  task automatic sc_run(input logic [31:0] a, input int gap,
                        input bit ex0, input bit sn0, input bit exm, input bit snm,
                        input logic [31:0] sa, input bit exp_upg, input bit exp_ok,
                        input string req);
    bit got = 1'b0;
    int w = 0;
    int up = 0;
    int i = 0;
    @(negedge clk);
    sc_valid = 1'b1; sc_addr = a;
    exc_pulse = ex0; snoop_valid = sn0; snoop_addr = sa;
    @(negedge clk);
    sc_valid = 1'b0; exc_pulse = 1'b0; snoop_valid = 1'b0;
    while (!got && i < 16) begin
      if (sc_done) begin
        got = 1'b1;
        chk(sc_pass == exp_ok, req, "sc_pass", int'(sc_pass), int'(exp_ok));
        chk(commit_stb == exp_ok, req, "commit_stb", int'(commit_stb), int'(exp_ok));
      end else if (upg_req) begin
        up++;
        exc_pulse   = exm && (w == 0);
        snoop_valid = snm && (w == 0);
        snoop_addr  = sa;
        upg_gnt     = (w == gap);
        w++;
      end
      @(negedge clk);
      exc_pulse = 1'b0; snoop_valid = 1'b0; upg_gnt = 1'b0;
      i++;
    end
    chk(got, req, "result seen", int'(got), 1);
    chk(!sc_done && !commit_stb, "R7", "done pulse length", int'(sc_done), 0);
    chk(!upg_req, "R6", "upg_req after result", int'(upg_req), 0);
    chk((up > 0) == exp_upg, req, "upgrade requested", up, int'(exp_upg));
    if (exp_upg) chk(up == gap + 1, "R6", "upg_req cycles", up, gap + 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    ll_valid = 0; sc_valid = 0; exc_pulse = 0; snoop_valid = 0; upg_gnt = 0;
    ll_addr = 0; sc_addr = 0; snoop_addr = 0;
    repeat (3) @(negedge clk);
    chk(!upg_req && !sc_done && !sc_pass && !commit_stb, "R12", "outputs in reset",
        int'({upg_req, sc_done, sc_pass, commit_stb}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!upg_req && !sc_done && !commit_stb, "R12", "outputs after reset",
        int'({upg_req, sc_done, commit_stb}), 0);
    sc_run(32'h0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
  endtask

  task automatic t_basic();
    do_ll(LINE_A, 0, 0, 0);
    sc_run(LINE_A, 0, 0, 0, 0, 0, 0, 1, 1, "R1");
    do_ll(LINE_A, 0, 0, 0);
    sc_run(BYTE_A, 3, 0, 0, 0, 0, 0, 1, 1, "R1");
  endtask

  task automatic t_second_sc();
    do_ll(LINE_B, 0, 0, 0);
    sc_run(LINE_B, 1, 0, 0, 0, 0, 0, 1, 1, "R8");
    sc_run(LINE_B, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    do_ll(LINE_B, 0, 0, 0);
    sc_run(LINE_C, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    sc_run(LINE_B, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
  endtask

  task automatic t_unlinked();
    sc_run(LINE_A, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
  endtask

  task automatic t_exception();
    do_ll(LINE_A, 0, 0, 0);
    do_exc();
    sc_run(LINE_A, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
  endtask

  task automatic t_snoop();
    do_ll(LINE_A, 0, 0, 0);
    do_snoop(BYTE_A);
    sc_run(LINE_A, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    do_ll(LINE_A, 0, 0, 0);
    do_snoop(LINE_B);
    sc_run(LINE_A, 0, 0, 0, 0, 0, 0, 1, 1, "R4");
  endtask

  task automatic t_pending();
    do_ll(LINE_A, 0, 0, 0);
    sc_run(LINE_A, 2, 0, 0, 0, 1, BYTE_A, 1, 0, "R9");
    do_ll(LINE_A, 0, 0, 0);
    sc_run(LINE_A, 2, 0, 0, 1, 0, 0, 1, 0, "R9");
    do_ll(LINE_A, 0, 0, 0);
    sc_run(LINE_A, 2, 0, 0, 0, 1, LINE_C, 1, 1, "R9");
  endtask

  task automatic t_same_cycle();
    do_ll(LINE_A, 1, 0, 0);
    sc_run(LINE_A, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    do_ll(LINE_C, 0, 1, LINE_C + 32'h4);
    sc_run(LINE_C, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    do_ll(LINE_A, 0, 0, 0);
    sc_run(LINE_A, 0, 1, 0, 0, 0, 0, 0, 0, "R13");
    do_ll(LINE_A, 0, 0, 0);
    sc_run(LINE_A, 0, 0, 1, 0, 0, BYTE_A, 0, 0, "R13");
  endtask

  task automatic t_replace();
    do_ll(LINE_A, 0, 0, 0);
    do_ll(LINE_B, 0, 0, 0);
    sc_run(LINE_A, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    do_ll(LINE_A, 0, 0, 0);
    do_ll(LINE_B, 0, 0, 0);
    sc_run(LINE_B, 0, 0, 0, 0, 0, 0, 1, 1, "R11");
  endtask

  task automatic t_stray_grant();
    @(negedge clk); upg_gnt = 1'b1;
    @(negedge clk); upg_gnt = 1'b0;
    chk(!sc_done && !commit_stb && !upg_req, "R6", "stray grant ignored",
        int'({sc_done, commit_stb, upg_req}), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_second_sc();
    t_unlinked();
    t_exception();
    t_snoop();
    t_pending();
    t_same_cycle();
    t_replace();
    t_stray_grant();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule